// File: doc/BRIEF.md
# Byte-Serial 16-Bit Add Sequencer

This block carries out the 16-bit register arithmetic of a small CPU whose only adder is 8 bits wide. A flag-producing 16-bit add is run as two passes through that one adder: the low bytes go first, and the high bytes follow with the carry of the first pass. Three such operations are covered. The first adds a register pair into HL. The second adds a sign-extended 8-bit offset to the stack pointer. The third loads HL with the stack pointer plus that offset. Increment and decrement of a register pair go through a separate 16-bit counter path that never touches the flags.

The operations differ in two ways: which pass leaves its flags behind, and when each destination byte appears on the write port. The pair add into HL writes L after the first pass and H after the second, so the flags shown between the two passes are the low-byte ones. The final flags come from the high byte. Both offset operations take half-carry and carry from the low-byte pass only. The stack-pointer form builds its result in a hidden temporary and then loads the whole stack pointer in a single cycle at the end. The surrounding core issues a one-cycle start with an operation code and operands, applies the byte writes to its register file, and waits for the done pulse.

Top module: `add16_seq`

## Requirements
- R1: Operation code 0 (pair add into HL) drives `wrLo` with `wrDest`=0 (HL) and `wrData[7:0]` = low byte of HL+RR in the first cycle after the start edge. In the second cycle it drives only `wrHi` with `wrDest`=0 and `wrData[15:8]` = high byte of HL+RR. `wrLo` and `wrHi` are never raised together for HL.
- R2: After operation code 0 completes, the flags (`flags[3]`=Z, `[2]`=N, `[1]`=H, `[0]`=C) hold Z = the `zeroIn` value sampled at start, N = 0, H = carry out of bit 11 and C = carry out of bit 15 of HL+RR.
- R3: During the high-byte write cycle of operation code 0, the flags show the low-byte pass: H = carry out of bit 3, C = carry out of bit 7, N = 0.
- R4: Operation code 1 (stack pointer plus offset) makes no write in its first two cycles. From the second cycle on, the flags read Z=0, N=0, H = carry out of bit 3 and C = carry out of bit 7 of SP[7:0] plus the unsigned offset byte. In the third cycle both strobes rise together with `wrDest`=1 (SP) and `wrData` = SP plus the sign-extended offset.
- R5: Operation code 2 (HL from stack pointer plus offset) writes L in the first cycle and H in the second (`wrDest`=0), using SP plus the sign-extended offset. Its flags follow the rule of R4 and appear in the second cycle. It never writes SP.
- R6: The offset is sign-extended, so the high-byte pass adds 0x00 or 0xFF. With SP=0xFFFF and offset 0xFF the result is 0xFFFE, with H and C both set.
- R7: Operation codes 3 (increment) and 4 (decrement) raise both strobes with `wrDest`=2 (pair) in the first cycle after start. `wrData` is RR plus or minus one, wrapping modulo 65536. The flags do not change.
- R8: `done` is a one-cycle pulse in the cycle after the last write. `busy` is high from the cycle after an accepted start up to and including the done cycle. A start raised while busy is ignored.
- R9: A start with an operation code from 5 to 7 is ignored: no busy, no write, no done, and the flags are unchanged.
- R10: After reset the flags are 0, and `busy`, `done`, `wrLo` and `wrHi` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, sampled when idle |
| opSel | input | 3 | Operation code (0..4 valid) |
| hlIn | input | 16 | Current HL |
| rrIn | input | 16 | Source register pair |
| spIn | input | 16 | Current stack pointer |
| offset | input | 8 | Signed 8-bit offset |
| zeroIn | input | 1 | Current Z flag, kept by the pair add |
| wrDest | output | 2 | Write target: 0 HL, 1 SP, 2 pair |
| wrLo | output | 1 | Low-byte write strobe |
| wrHi | output | 1 | High-byte write strobe |
| wrData | output | 16 | Write data, byte lanes per strobe |
| flags | output | 4 | Z, N, H, C |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |

## Verification
The assertions assume that operands and the operation code are valid in the cycle where start is sampled. They also assume that start carries meaning only while the block is idle, and that the core does not depend on the operand inputs after that edge. The stimulus holds operands steady over the start edge. It then changes them freely, and in some runs it keeps start high with a different operation code while busy, so the ignored-start path is exercised. Operation codes 5 to 7 also appear in the random mix.

// File: rtl/add16_pkg.sv
package add16_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_HL   = 3'd0,
    OP_ADD_SP   = 3'd1,
    OP_LD_HL_SP = 3'd2,
    OP_INC      = 3'd3,
    OP_DEC      = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    DST_HL = 2'd0,
    DST_SP = 2'd1,
    DST_RR = 2'd2
  } dst_e;

  typedef struct packed {
    logic latch;     // capture operands on an accepted start
    logic stepLo;    // low-byte ALU pass
    logic stepHi;    // high-byte ALU pass
    logic loadFull;  // one-cycle load of the temporary into SP
    logic incDec;    // 16-bit counter path
  } strobe_t;

  function automatic logic opIsValid(input logic [OP_W-1:0] code);
    return code <= OP_W'(OP_DEC);
  endfunction
endpackage

// File: rtl/add16_alu8.sv
module add16_alu8 #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         halfOut,
  output logic         carryOut
);
  localparam int HW = W / 2;

  logic [W:0]  full;
  logic [HW:0] lower;

  always_comb begin
    full     = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    lower    = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
    sum      = full[W-1:0];
    carryOut = full[W];
    halfOut  = lower[HW];
  end
endmodule

// File: rtl/add16_incdec.sv
module add16_incdec #(
  parameter int W = 16
) (
  input  logic [W-1:0] value,
  input  logic         down,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb result = down ? (value - ONE) : (value + ONE);
endmodule

// File: rtl/add16_ctrl.sv
module add16_ctrl
  import add16_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OP_W-1:0] opSel,
  output strobe_t         strobe,
  output op_e             opQ,
  output logic            busy,
  output logic            done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LO, ST_HI, ST_LOAD, ST_CNT, ST_FIN
  } state_e;

  state_e state;
  logic   accept;

  assign accept = (state == ST_IDLE) && start && opIsValid(opSel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      opQ   <= OP_ADD_HL;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          opQ   <= op_e'(opSel);
          state <= (opSel == OP_INC || opSel == OP_DEC) ? ST_CNT : ST_LO;
        end
        ST_LO:   state <= ST_HI;
        ST_HI:   state <= (opQ == OP_ADD_SP) ? ST_LOAD : ST_FIN;
        ST_LOAD: state <= ST_FIN;
        ST_CNT:  state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.latch    = accept;
    strobe.stepLo   = (state == ST_LO);
    strobe.stepHi   = (state == ST_HI);
    strobe.loadFull = (state == ST_LOAD);
    strobe.incDec   = (state == ST_CNT);
    busy            = (state != ST_IDLE);
    done            = (state == ST_FIN);
  end
endmodule

// File: rtl/add16_dp.sv
module add16_dp
  import add16_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobe,
  input  op_e               opQ,
  input  logic [OP_W-1:0]   opSel,
  input  logic [2*BYTE_W-1:0] hlIn,
  input  logic [2*BYTE_W-1:0] rrIn,
  input  logic [2*BYTE_W-1:0] spIn,
  input  logic [BYTE_W-1:0] offset,
  input  logic              zeroIn,
  output logic [1:0]        wrDest,
  output logic              wrLo,
  output logic              wrHi,
  output logic [2*BYTE_W-1:0] wrData,
  output logic [3:0]        flags
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int FZ = 3, FN = 2, FH = 1, FC = 0;

  logic [WORD_W-1:0] aQ, bQ, cntOut, offExt;
  logic [BYTE_W-1:0] tmpLo, tmpHi, aluA, aluB, aluSum;
  logic              carryQ, zeroQ, aluCin, aluHalf, aluCarry, spOp;
  logic [3:0]        flagQ;

  assign offExt = {{BYTE_W{offset[BYTE_W-1]}}, offset};
  assign spOp   = (opQ == OP_ADD_SP) || (opQ == OP_LD_HL_SP);

  // operand capture: A is the destination-side word, B the addend
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aQ    <= '0;
      bQ    <= '0;
      zeroQ <= 1'b0;
    end else if (strobe.latch) begin
      zeroQ <= zeroIn;
      case (opSel)
        OP_ADD_HL:            begin aQ <= hlIn; bQ <= rrIn;   end
        OP_ADD_SP, OP_LD_HL_SP: begin aQ <= spIn; bQ <= offExt; end
        default:              begin aQ <= rrIn; bQ <= '0;     end
      endcase
    end
  end

  // the single byte-wide adder, shared by both passes
  always_comb begin
    aluA   = strobe.stepHi ? aQ[WORD_W-1:BYTE_W] : aQ[BYTE_W-1:0];
    aluB   = strobe.stepHi ? bQ[WORD_W-1:BYTE_W] : bQ[BYTE_W-1:0];
    aluCin = strobe.stepHi & carryQ;
  end

  add16_alu8 #(.W(BYTE_W)) u_alu (
    .a(aluA), .b(aluB), .cin(aluCin),
    .sum(aluSum), .halfOut(aluHalf), .carryOut(aluCarry)
  );

  add16_incdec #(.W(WORD_W)) u_cnt (
    .value(aQ), .down(opQ == OP_DEC), .result(cntOut)
  );

  // hidden temporary and flag register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmpLo  <= '0;
      tmpHi  <= '0;
      carryQ <= 1'b0;
      flagQ  <= '0;
    end else begin
      if (strobe.stepLo) begin
        tmpLo     <= aluSum;
        carryQ    <= aluCarry;
        flagQ[FN] <= 1'b0;
        flagQ[FH] <= aluHalf;
        flagQ[FC] <= aluCarry;
        flagQ[FZ] <= spOp ? 1'b0 : zeroQ;
      end
      if (strobe.stepHi) begin
        tmpHi <= aluSum;
        if (opQ == OP_ADD_HL) begin
          flagQ[FH] <= aluHalf;
          flagQ[FC] <= aluCarry;
        end
      end
    end
  end

  // register-file write port
  always_comb begin
    wrDest = DST_HL;
    wrLo   = 1'b0;
    wrHi   = 1'b0;
    wrData = '0;
    if (strobe.loadFull) begin
      wrDest = DST_SP;
      wrLo   = 1'b1;
      wrHi   = 1'b1;
      wrData = {tmpHi, tmpLo};
    end else if (strobe.incDec) begin
      wrDest = DST_RR;
      wrLo   = 1'b1;
      wrHi   = 1'b1;
      wrData = cntOut;
    end else if (strobe.stepLo && opQ != OP_ADD_SP) begin
      wrLo   = 1'b1;
      wrData = {{BYTE_W{1'b0}}, aluSum};
    end else if (strobe.stepHi && opQ != OP_ADD_SP) begin
      wrHi   = 1'b1;
      wrData = {aluSum, tmpLo};
    end
  end

  assign flags = flagQ;
endmodule

// File: rtl/add16_seq.sv
module add16_seq
  import add16_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          opSel,
  input  logic [2*BYTE_W-1:0] hlIn,
  input  logic [2*BYTE_W-1:0] rrIn,
  input  logic [2*BYTE_W-1:0] spIn,
  input  logic [BYTE_W-1:0]   offset,
  input  logic                zeroIn,
  output logic [1:0]          wrDest,
  output logic                wrLo,
  output logic                wrHi,
  output logic [2*BYTE_W-1:0] wrData,
  output logic [3:0]          flags,
  output logic                busy,
  output logic                done
);
  strobe_t strobe;
  op_e     opQ;

  add16_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .opSel(opSel),
    .strobe(strobe), .opQ(opQ), .busy(busy), .done(done)
  );

  add16_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opQ(opQ), .opSel(opSel),
    .hlIn(hlIn), .rrIn(rrIn), .spIn(spIn), .offset(offset), .zeroIn(zeroIn),
    .wrDest(wrDest), .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData), .flags(flags)
  );
endmodule

// File: rtl/add16_seq_chk.sv
module add16_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [2:0] opSel,
  input logic [1:0] wrDest,
  input logic       wrLo,
  input logic       wrHi,
  input logic [3:0] flags,
  input logic       busy,
  input logic       done
);
  assert_hl_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrLo && !wrHi && wrDest == 2'd0) |=> (wrHi && !wrLo && wrDest == 2'd0));

  assert_hl_bytewise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrLo && wrHi) |-> (wrDest != 2'd0));

  assert_sp_atomic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrDest == 2'd1 && (wrLo || wrHi)) |-> (wrLo && wrHi));

  assert_cnt_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (opSel == 3'd3 || opSel == 3'd4)) |=> ($stable(flags) ##1 $stable(flags)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wrLo || wrHi));

  assert_bad_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && opSel > 3'd4) |=> (!busy && $stable(flags)));
endmodule

bind add16_seq add16_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .opSel(opSel),
  .wrDest(wrDest), .wrLo(wrLo), .wrHi(wrHi), .flags(flags),
  .busy(busy), .done(done)
);

// File: tb/add16_seq_tb.sv
module add16_seq_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, zeroIn;
  logic [2:0]  opSel;
  logic [15:0] hlIn, rrIn, spIn;
  logic [7:0]  offset;
  logic [1:0]  wrDest;
  logic        wrLo, wrHi, busy, done;
  logic [15:0] wrData;
  logic [3:0]  flags;

  add16_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opSel(opSel),
    .hlIn(hlIn), .rrIn(rrIn), .spIn(spIn), .offset(offset), .zeroIn(zeroIn),
    .wrDest(wrDest), .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData),
    .flags(flags), .busy(busy), .done(done)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  logic [3:0] refFlags;

  typedef struct {
    bit        lo, hi, bsy, dn;
    bit [1:0]  dst;
    bit [15:0] data;
    bit [3:0]  fl;
  } exp_t;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareCycle(input exp_t e, input string req);
    check({wrLo, wrHi, busy, done} == {e.lo, e.hi, e.bsy, e.dn}, "R8", "strobes",
          {wrLo, wrHi, busy, done}, {e.lo, e.hi, e.bsy, e.dn});
    if (e.lo || e.hi) check(wrDest == e.dst, req, "dest", wrDest, e.dst);
    if (e.lo) check(wrData[7:0] == e.data[7:0], req, "lowbyte", wrData[7:0], e.data[7:0]);
    if (e.hi) check(wrData[15:8] == e.data[15:8], req, "highbyte", wrData[15:8], e.data[15:8]);
    check(flags == e.fl, req, "flags", flags, e.fl);
  endtask

  function automatic exp_t mk(bit lo, bit hi, bit [1:0] dst, bit [15:0] data,
                              bit [3:0] fl, bit bsy, bit dn);
    exp_t e;
    e.lo = lo; e.hi = hi; e.dst = dst; e.data = data;
    e.fl = fl; e.bsy = bsy; e.dn = dn;
    return e;
  endfunction

  task automatic runOp(input bit [2:0] op, input bit [15:0] hl, input bit [15:0] rr,
                       input bit [15:0] sp, input bit [7:0] e8, input bit z,
                       input bit holdStart);
    exp_t q[$];
    string req;
    int lo9, hi9, hHalf, lHalf, ext, res;
    bit [3:0] old = refFlags;
    bit [3:0] fl1, fl2;
    ext = e8[7] ? (32'hFF00 | e8) : e8;
    case (op)
      3'd0: begin
        req   = "R1";
        lo9   = hl[7:0] + rr[7:0];
        lHalf = ((hl[3:0] + rr[3:0]) > 15) ? 1 : 0;
        hi9   = hl[15:8] + rr[15:8] + lo9[8];
        hHalf = ((hl[11:8] + rr[11:8] + lo9[8]) > 15) ? 1 : 0;
        fl1   = {z, 1'b0, lHalf[0], lo9[8]};   // R3 transient
        fl2   = {z, 1'b0, hHalf[0], hi9[8]};   // R2 final
        q.push_back(mk(1, 0, 0, {8'h00, lo9[7:0]}, old, 1, 0));
        q.push_back(mk(0, 1, 0, {hi9[7:0], 8'h00}, fl1, 1, 0));
        q.push_back(mk(0, 0, 0, 0, fl2, 1, 1));
        refFlags = fl2;
      end
      3'd1, 3'd2: begin
        req   = (op == 3'd1) ? "R4" : "R5";
        lo9   = sp[7:0] + e8;
        lHalf = ((sp[3:0] + e8[3:0]) > 15) ? 1 : 0;
        res   = (sp + ext) & 16'hFFFF;
        fl1   = {1'b0, 1'b0, lHalf[0], lo9[8]};
        if (op == 3'd1) begin
          q.push_back(mk(0, 0, 0, 0, old, 1, 0));
          q.push_back(mk(0, 0, 0, 0, fl1, 1, 0));
          q.push_back(mk(1, 1, 1, res[15:0], fl1, 1, 0));
          q.push_back(mk(0, 0, 0, 0, fl1, 1, 1));
        end else begin
          q.push_back(mk(1, 0, 0, res[15:0], old, 1, 0));
          q.push_back(mk(0, 1, 0, res[15:0], fl1, 1, 0));
          q.push_back(mk(0, 0, 0, 0, fl1, 1, 1));
        end
        refFlags = fl1;
      end
      3'd3, 3'd4: begin
        req = "R7";
        res = ((op == 3'd3) ? (rr + 1) : (rr + 16'hFFFF)) & 16'hFFFF;
        q.push_back(mk(1, 1, 2, res[15:0], old, 1, 0));
        q.push_back(mk(0, 0, 0, 0, old, 1, 1));
      end
      default: begin
        req = "R9";
        q.push_back(mk(0, 0, 0, 0, old, 0, 0));
      end
    endcase

    @(negedge clk);
    opSel = op; hlIn = hl; rrIn = rr; spIn = sp; offset = e8; zeroIn = z;
    start = 1'b1;
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      if (holdStart && op <= 3'd4) begin
        opSel = 3'd3; rrIn = $urandom; hlIn = $urandom; spIn = $urandom;
        offset = $urandom; zeroIn = ~z;
      end else begin
        start = 1'b0;
        hlIn = $urandom; rrIn = $urandom; spIn = $urandom; offset = $urandom;
      end
      compareCycle(q[i], req);
    end
    @(negedge clk);
    start = 1'b0;
    // idle after completion: a held start must not have launched anything
    compareCycle(mk(0, 0, 0, 0, refFlags, 0, 0), "R8");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL R8 watchdog actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; opSel = '0; hlIn = '0; rrIn = '0;
    spIn = '0; offset = '0; zeroIn = 1'b0;
    refFlags = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check({busy, done, wrLo, wrHi} == 4'b0, "R10", "strobes", {busy, done, wrLo, wrHi}, 0);
    check(flags == 4'h0, "R10", "flags", flags, 0);

    runOp(3'd1, 16'hFFFF, 0, 16'hFFFF, 8'hFF, 0, 0);   // R6 corner: FFFE, H and C
    runOp(3'd1, 0, 0, 16'h00F0, 8'h10, 1, 0);          // R6 positive carry into high byte
    runOp(3'd2, 0, 0, 16'h0000, 8'hFF, 0, 0);          // R5 with borrow-like wrap
    runOp(3'd0, 16'h0FFF, 16'h0001, 0, 0, 1, 0);       // R3 low carry, R2 bit 11
    runOp(3'd0, 16'hFFFF, 16'h0001, 0, 0, 0, 0);       // R2 bit 15 carry, result 0
    runOp(3'd0, 16'h0808, 16'h0808, 0, 0, 1, 0);       // R3 half-carry both bytes
    runOp(3'd3, 0, 16'hFFFF, 0, 0, 0, 0);              // R7 increment wrap
    runOp(3'd4, 0, 16'h0000, 0, 0, 0, 0);              // R7 decrement wrap
    runOp(3'd5, 16'h1234, 16'h1111, 16'h2222, 8'h01, 1, 0); // R9
    runOp(3'd7, 0, 0, 0, 0, 0, 0);                     // R9
    runOp(3'd1, 16'h0, 16'h0, 16'h1234, 8'h80, 0, 1);  // R8 start held while busy
    runOp(3'd0, 16'h00FF, 16'h0001, 0, 0, 1, 1);       // R8 start held while busy

    for (int n = 0; n < 400; n++) begin
      bit [2:0] op = 3'($urandom_range(0, 7));
      runOp(op, 16'($urandom), 16'($urandom), 16'($urandom), 8'($urandom),
            1'($urandom), 1'($urandom_range(0, 3) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule